// File: doc/BRIEF.md
# SDRAM Single-Bank Read Sequencer

This block sits on the controller side of a synchronous DRAM. It takes one read request at a time and turns it into a complete command sequence on the DRAM command/address bus. A request carries a bank, a row, a starting column and a flag that selects automatic precharge. The block opens the row, issues the read and closes the row. The close is either an explicit precharge command or the precharge the device starts by itself. The block then holds off the next request until the same bank may be opened again.

All minimum intervals are given as nanosecond parameters together with the clock period. Each one becomes a cycle count at elaboration time, rounded up. The four returned data words of the burst are sampled from the DRAM data input after the programmed CAS latency. They are presented on a registered output with a valid strobe. Refresh, writes, mode programming and bank interleaving are handled elsewhere.

Top module: `sdrs_read_seq`

## Requirements
- R1: After synchronous reset the command output is NOP (code 0), `req_ready` is high and `rd_valid` is low.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. ACTIVE (code 1) appears in the following cycle, with the request bank on `sd_ba` and the row on `sd_addr`.
- R3: READ (code 2) appears exactly tRCD cycles after ACTIVE. The column is in the low bits of `sd_addr` and the auto-precharge flag is on `sd_ap`.
- R4: `rd_valid` is high for exactly 4 consecutive cycles, starting CAS_LAT+1 cycles after READ. `rd_data` carries the DRAM word sampled in the cycle before each of those cycles.
- R5: Without auto precharge, PRECHARGE (code 3, `sd_ap` low, request bank) appears at ACTIVE + max(tRCD+4, tRAS) cycles. With auto precharge, no PRECHARGE command is driven, and the device-side precharge is taken to start at that same cycle.
- R6: `req_ready` is low from the cycle after acceptance until the next ACTIVE can meet both the precharge period and the ACTIVE-to-ACTIVE period. The next ACTIVE may come no earlier than max(P+tRP, tRC, P+2) cycles after the previous ACTIVE, where P is the precharge offset from R5.
- R7: In every cycle in which no ACTIVE, READ or PRECHARGE is due, the command output is NOP, including while a request waits for `req_ready`.
- R8: Every interval is converted to cycles by dividing the nanosecond value by the clock period and rounding up to the next integer, with a floor of one cycle.
- R9: A row is never held open for tRAS-max cycles or longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request starting column |
| req_autopre | input | 1 | Close row by auto precharge |
| sd_cmd | output | 2 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 PRECHARGE |
| sd_ba | output | BANK_W | Bank address to DRAM |
| sd_addr | output | ROW_W | Row or column address to DRAM |
| sd_ap | output | 1 | Auto-precharge flag sent with READ |
| sd_rdata | input | DATA_W | Data word from DRAM |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a burst word |

## Verification
The bench takes acceptance cycle A as the time origin. From it, ACTIVE is due at A+1 and READ at A+1+tRCD. The four data strobes are due at A+2+tRCD+CAS_LAT onward, and PRECHARGE at A+1+P. `req_ready` is due to rise at A+max(P+tRP, tRC, P+2). All of these offsets come from the bench's own rounded-up conversion of the nanosecond parameters. The driver queues each event with its due cycle. The monitor samples on the falling edge, so every comparison falls mid-cycle, and it fails any command or strobe whose cycle or fields differ. A DRAM stub separately flags any command that arrives earlier than its minimum interval.

// File: rtl/sdrs_pkg.sv
// Shared types and helpers for the SDRAM read sequencer.
// Assumes command codes are fixed by the command/address bus of the DRAM side.
package sdrs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } sdrs_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_BURST = 2'd2,
        ST_RECOV = 2'd3
    } sdrs_state_e;

    // Nanoseconds to whole cycles, rounded up, never below one cycle.
    function automatic int cyc_ceil(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdrs_age_ctr.sv
// Saturating cycle counter: cleared to zero together with the command it times,
// so it reads zero in the cycle that command is on the bus.
// Assumes reset means "long ago", so it resets to the saturated value.
module sdrs_age_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] AGE_MAX = '1;

    // Count cycles since the last clear, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= AGE_MAX;
        else if (clr)
            age <= '0;
        else if (age != AGE_MAX)
            age <= age + 1'b1;
    end
endmodule

// File: rtl/sdrs_capture.sv
// Read data capture: delays the READ marker by the CAS latency, then samples
// BL consecutive words from the DRAM and presents them registered with a strobe.
// Assumes CL >= 2 and that a new READ never starts before the previous burst ends.
module sdrs_capture #(
    parameter int DATA_W = 16,
    parameter int CL     = 2,
    parameter int BL     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issued,
    input  logic [DATA_W-1:0] dram_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int BW = $clog2(BL + 1);
    localparam logic [BW-1:0] BEATS_REST = BW'(BL - 1);

    logic [CL-1:0] pend;
    logic [BW-1:0] beats_left;
    logic          first_beat;

    assign first_beat = pend[CL-1];

    // Shift the READ marker so its top bit marks the first data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= {pend[CL-2:0], rd_issued};
    end

    // Sample the data bus during the burst window and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            beats_left <= '0;
        end else if (first_beat || beats_left != '0) begin
            rd_valid   <= 1'b1;
            rd_data    <= dram_data;
            beats_left <= first_beat ? BEATS_REST : beats_left - 1'b1;
        end else begin
            rd_valid   <= 1'b0;
        end
    end

    // R4: a burst window never opens while the previous one is still running.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        first_beat |-> (beats_left == '0));

    // R4: the strobe drops only after the full burst has been delivered.
    a_r4_full_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && beats_left != '0) |=> rd_valid);
endmodule

// File: rtl/sdrs_read_seq.sv
// Single-bank read sequencer for a synchronous DRAM.
// Accepts one request at a time and issues ACTIVE, READ, then PRECHARGE (or
// leaves the close to the device's auto precharge). Every minimum interval is
// derived from nanosecond parameters and the clock period, rounded up.
// Assumes: CAS_LAT is 2 or 3, burst length is fixed at BURST_LEN, ROW_W >= COL_W,
// and the device is in idle, precharged state after reset.
module sdrs_read_seq #(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 16,
    parameter int CLK_NS       = 10,
    parameter int T_RCD_NS     = 19,
    parameter int T_RAS_NS     = 45,
    parameter int T_RAS_MAX_NS = 100000,
    parameter int T_RP_NS      = 19,
    parameter int T_RC_NS      = 67,
    parameter int CAS_LAT      = 2,
    parameter int BURST_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_autopre,
    output logic [1:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              sd_ap,
    input  logic [DATA_W-1:0] sd_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    import sdrs_pkg::*;

    // R8: interval lengths in cycles, rounded up.
    localparam int RCD_C    = cyc_ceil(T_RCD_NS, CLK_NS);
    localparam int RAS_C    = cyc_ceil(T_RAS_NS, CLK_NS);
    localparam int RASMAX_C = cyc_ceil(T_RAS_MAX_NS, CLK_NS);
    localparam int RP_C     = cyc_ceil(T_RP_NS, CLK_NS);
    localparam int RC_C     = cyc_ceil(T_RC_NS, CLK_NS);
    localparam int MAX_C    = (RASMAX_C > RC_C) ? RASMAX_C : RC_C;
    localparam int AGE_W    = $clog2(MAX_C + 3);

    localparam logic [AGE_W:0] RCD_L    = (AGE_W+1)'(RCD_C);
    localparam logic [AGE_W:0] RAS_L    = (AGE_W+1)'(RAS_C);
    localparam logic [AGE_W:0] RASMAX_L = (AGE_W+1)'(RASMAX_C);
    localparam logic [AGE_W:0] RP_L     = (AGE_W+1)'(RP_C);
    localparam logic [AGE_W:0] RC_L     = (AGE_W+1)'(RC_C);
    localparam logic [AGE_W:0] BL_L     = (AGE_W+1)'(BURST_LEN);
    localparam logic [AGE_W:0] ONE_L    = (AGE_W+1)'(1);
    localparam logic [AGE_W:0] TWO_L    = (AGE_W+1)'(2);

    sdrs_state_e       state, state_d;
    sdrs_cmd_e         cmd_q, cmd_d;
    logic [BANK_W-1:0] ba_d, bank_q;
    logic [ROW_W-1:0]  addr_d;
    logic              ap_d;
    logic [COL_W-1:0]  col_q;
    logic              autopre_q;
    logic              clr_act, clr_rd, clr_pre;
    logic [AGE_W-1:0]  act_age, rd_age, pre_age;
    logic [AGE_W:0]    act_n1, act_n2, rd_n1, pre_n2;
    logic              row_open;

    // Cycles since the last ACTIVE, READ and precharge start.
    sdrs_age_ctr #(.W(AGE_W)) u_act_age (
        .clk(clk), .rst_n(rst_n), .clr(clr_act), .age(act_age));
    sdrs_age_ctr #(.W(AGE_W)) u_rd_age (
        .clk(clk), .rst_n(rst_n), .clr(clr_rd), .age(rd_age));
    sdrs_age_ctr #(.W(AGE_W)) u_pre_age (
        .clk(clk), .rst_n(rst_n), .clr(clr_pre), .age(pre_age));

    // Ages as they will be in the next cycle (and the one after).
    assign act_n1 = {1'b0, act_age} + ONE_L;
    assign act_n2 = {1'b0, act_age} + TWO_L;
    assign rd_n1  = {1'b0, rd_age}  + ONE_L;
    assign pre_n2 = {1'b0, pre_age} + TWO_L;

    assign req_ready = (state == ST_IDLE);
    assign row_open  = (state == ST_OPEN) || (state == ST_BURST);
    assign sd_cmd    = cmd_q;

    // Pick the command for the next cycle and the next state.
    always_comb begin
        state_d = state;
        cmd_d   = CMD_NOP;
        ba_d    = bank_q;
        addr_d  = '0;
        ap_d    = 1'b0;
        clr_act = 1'b0;
        clr_rd  = 1'b0;
        clr_pre = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    cmd_d   = CMD_ACT;
                    ba_d    = req_bank;
                    addr_d  = req_row;
                    clr_act = 1'b1;
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (act_n1 >= RCD_L) begin
                    cmd_d   = CMD_RD;
                    addr_d  = ROW_W'(col_q);
                    ap_d    = autopre_q;
                    clr_rd  = 1'b1;
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                if (rd_n1 >= BL_L && act_n1 >= RAS_L) begin
                    cmd_d   = autopre_q ? CMD_NOP : CMD_PRE;
                    clr_pre = 1'b1;
                    state_d = ST_RECOV;
                end
            end
            ST_RECOV: begin
                if (act_n2 >= RC_L && pre_n2 >= RP_L)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register the state and the command/address bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
            sd_ap   <= 1'b0;
        end else begin
            state   <= state_d;
            cmd_q   <= cmd_d;
            sd_ba   <= ba_d;
            sd_addr <= addr_d;
            sd_ap   <= ap_d;
        end
    end

    // Hold the request fields needed after ACTIVE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q    <= '0;
            col_q     <= '0;
            autopre_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            bank_q    <= req_bank;
            col_q     <= req_col;
            autopre_q <= req_autopre;
        end
    end

    sdrs_capture #(
        .DATA_W(DATA_W),
        .CL    (CAS_LAT),
        .BL    (BURST_LEN)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issued(cmd_q == CMD_RD),
        .dram_data(sd_rdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R2: an accepted request puts ACTIVE on the bus in the next cycle.
    a_r2_act_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (sd_cmd == CMD_ACT));

    // R3: READ never comes before the row-to-column minimum.
    a_r3_rcd_met: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD) |-> ({1'b0, act_age} >= RCD_L));

    // R5: PRECHARGE waits for both the row-active minimum and the burst.
    a_r5_ras_met: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE) |-> ({1'b0, act_age} >= RAS_L && {1'b0, rd_age} >= BL_L));

    // R6: a new ACTIVE respects the row-cycle and precharge periods.
    a_r6_rc_met: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_ACT) |-> ({1'b0, $past(act_age)} + ONE_L >= RC_L));
    a_r6_rp_met: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_ACT) |-> ({1'b0, $past(pre_age)} + ONE_L >= RP_L));

    // R7: while waiting for a request only NOP is driven.
    a_r7_ready_nop: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sd_cmd == CMD_NOP));

    // R9: an open row is closed before the row-active maximum.
    a_r9_open_limit: assert property (@(posedge clk) disable iff (!rst_n)
        row_open |-> ({1'b0, act_age} < RASMAX_L));
endmodule

// File: tb/sim_sdrs_read_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the due cycle and fields of every command
// and data word; the monitor pops and compares on the falling edge. A DRAM stub
// returns a column-derived pattern and flags commands that come too early.
module sim_sdrs_read_seq;
    localparam int CLK_NS = 10;
    localparam int RCD_NS = 19;
    localparam int RAS_NS = 65;
    localparam int RP_NS  = 19;
    localparam int RC_NS  = 95;
    localparam int CL     = 2;
    localparam int BL     = 4;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R8: independent rounded-up cycle counts (65 ns -> 7, 95 ns -> 10).
    localparam int RCD = cdiv(RCD_NS);
    localparam int RAS = cdiv(RAS_NS);
    localparam int RP  = cdiv(RP_NS);
    localparam int RC  = cdiv(RC_NS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_autopre = 1'b0;
    logic [1:0]  sd_cmd;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        sd_ap;
    logic [15:0] sd_rdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    sdrs_read_seq #(
        .CLK_NS(CLK_NS), .T_RCD_NS(RCD_NS), .T_RAS_NS(RAS_NS),
        .T_RP_NS(RP_NS), .T_RC_NS(RC_NS), .CAS_LAT(CL), .BURST_LEN(BL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_autopre(req_autopre), .sd_cmd(sd_cmd), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_ap(sd_ap), .sd_rdata(sd_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    typedef struct {
        int          at;
        logic [1:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        ap;
    } cmd_exp_t;
    typedef struct {
        int          at;
        logic [15:0] d;
    } dat_exp_t;

    cmd_exp_t cmd_sb[$];
    dat_exp_t dat_sb[$];
    int busy_lo = 0;
    int busy_hi = -1;

    function automatic logic [15:0] pattern(input logic [1:0] b, input logic [12:0] r,
                                            input logic [9:0] c);
        return {b, r[3:0], c};
    endfunction

    // Driver: wait for acceptance, then queue everything due from it.
    task automatic request(input logic [1:0] b, input logic [12:0] r,
                           input logic [9:0] c, input logic ap);
        int a;
        int c0;
        int p;
        int nxt;
        @(negedge clk);
        req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_autopre = ap;
        while (!req_ready) @(negedge clk);
        a   = cyc;
        c0  = a + 1;
        p   = imax(RCD + BL, RAS);
        nxt = imax(imax(p + RP, RC), p + 2);
        cmd_sb.push_back('{c0, 2'd1, b, r, 1'b0});
        cmd_sb.push_back('{c0 + RCD, 2'd2, b, {3'b0, c}, ap});
        if (!ap) cmd_sb.push_back('{c0 + p, 2'd3, b, 13'd0, 1'b0});
        for (int i = 0; i < BL; i++) begin
            logic [9:0] cw;
            cw = {c[9:2], 2'(c[1:0] + 2'(i))};
            dat_sb.push_back('{c0 + RCD + CL + 1 + i, pattern(b, r, cw)});
        end
        busy_lo = a + 1;
        busy_hi = a + nxt - 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // DRAM stub: drives the burst and flags commands issued too early.
    int          st_act = -1000;
    int          st_rd = -1000;
    int          st_pre = -1000;
    logic [1:0]  st_b;
    logic [12:0] st_r;
    logic [9:0]  st_c;
    always @(negedge clk) begin
        if (rst_n) begin
            case (sd_cmd)
                2'd1: begin
                    check(cyc - st_act >= RC, "R6", "stub ACT-to-ACT gap", cyc - st_act, RC);
                    check(cyc - st_pre >= RP, "R6", "stub PRE-to-ACT gap", cyc - st_pre, RP);
                    st_act = cyc; st_r = sd_addr; st_b = sd_ba;
                end
                2'd2: begin
                    check(cyc - st_act >= RCD, "R3", "stub ACT-to-READ gap", cyc - st_act, RCD);
                    st_rd = cyc; st_c = sd_addr[9:0];
                    if (sd_ap) st_pre = imax(st_rd + BL, st_act + RAS);
                end
                2'd3: begin
                    check(cyc - st_act >= RAS, "R5", "stub ACT-to-PRE gap", cyc - st_act, RAS);
                    check(cyc - st_rd >= BL, "R5", "stub READ-to-PRE gap", cyc - st_rd, BL);
                    st_pre = cyc;
                end
                default: ;
            endcase
        end
        if (cyc >= st_rd + CL && cyc < st_rd + CL + BL)
            sd_rdata = pattern(st_b, st_r, {st_c[9:2], 2'(st_c[1:0] + 2'(cyc - st_rd - CL))});
        else
            sd_rdata = 16'hDEAD;
    end

    // Monitor: compare bus commands, data strobes and ready with the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sd_cmd != 2'd0) begin
                if (cmd_sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected command", sd_cmd, 0);
                end else begin
                    cmd_exp_t e;
                    e = cmd_sb.pop_front();
                    check(cyc == e.at, "R2/R3/R5", "command cycle", cyc, e.at);
                    check(sd_cmd == e.cmd, "R2/R3/R5", "command code", sd_cmd, e.cmd);
                    check(sd_ba == e.ba, "R2", "bank", sd_ba, e.ba);
                    check(sd_addr == e.addr, "R2/R3", "address", sd_addr, e.addr);
                    check(sd_ap == e.ap, "R3", "auto-precharge flag", sd_ap, e.ap);
                end
            end
            if (rd_valid) begin
                if (dat_sb.size() == 0) begin
                    check(1'b0, "R4", "unexpected rd_valid", 1, 0);
                end else begin
                    dat_exp_t d;
                    d = dat_sb.pop_front();
                    check(cyc == d.at, "R4", "data cycle", cyc, d.at);
                    check(rd_data == d.d, "R4", "data word", rd_data, d.d);
                end
            end
            check(req_ready == !(cyc >= busy_lo && cyc <= busy_hi), "R6", "req_ready",
                  req_ready, !(cyc >= busy_lo && cyc <= busy_hi));
        end
    end

    bit done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sd_cmd == 2'd0, "R1", "reset cmd", sd_cmd, 0);
        check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        check(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sd_cmd == 2'd0 && req_ready, "R1", "idle after reset", sd_cmd, 0);
        mon_on = 1'b1;
        // R2 R3 R4 R5 R8: explicit precharge, aligned column.
        request(2'd1, 13'd100, 10'd0, 1'b0);
        // R6 R7: back-to-back, valid held while ready low; auto precharge, wrapped order.
        request(2'd2, 13'h1ABC, 10'd5, 1'b1);
        // R4: wrap at top of the aligned group.
        request(2'd3, 13'd7, 10'h3FE, 1'b0);
        // R7: idle gap with no request must stay NOP.
        repeat (15) @(negedge clk);
        request(2'd0, 13'h1FFF, 10'h201, 1'b1);
        repeat (25) @(negedge clk);
        check(cmd_sb.size() == 0, "R5", "commands outstanding", cmd_sb.size(), 0);
        check(dat_sb.size() == 0, "R4", "data outstanding", dat_sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule